// File: doc/BRIEF.md
# Dual-Channel IDE Bus-Master Register Block

This block holds the byte-addressed registers that software uses to program the bus-master DMA function of a two-channel IDE controller. Each channel owns an 8-byte bank inside a 16-byte I/O window. A bank holds a command byte, a status byte, a drive-timing byte and a 32-bit descriptor-table pointer. Both banks also reach one shared mode byte, which collects the interrupt state of both channels.

Each channel's level interrupt input is copied into a pending bit of the mode byte. The block merges the two channels into one PCI interrupt line. Software can hold back either channel through a block bit in the mode byte. Every channel's status byte also records interrupt edges and DMA faults in write-1-to-clear bits, so that software can acknowledge them.

The transfer engine, the task-file registers and configuration-space decoding sit outside this block. The engine only supplies a one-cycle fault pulse per channel.

Top module: `idebm_regs`

## Requirements
- R1: Offsets 0–7 address channel 0 and offsets 8–15 address channel 1. Within a bank, byte 0 is command, byte 1 is mode, byte 2 is status, byte 3 is timing and bytes 4–7 are the table pointer. Byte 1 of either bank reaches the same single mode register.
- R2: A write to the mode byte changes only bit 4 (block channel 0, 0x10) and bit 5 (block channel 1, 0x20). Bits 2 and 3 are not writable, and bits 0, 1, 6 and 7 read as zero.
- R3: Mode bit 2 (channel 0 pending, 0x04) and bit 3 (channel 1 pending, 0x08) take the level of that channel's `chanIrq` input on every clock edge.
- R4: `irqOut` equals (bit2 AND NOT bit4) OR (bit3 AND NOT bit5) of the mode register, so it follows any pending or block change without further delay.
- R5: A status write loads bits 5 and 6 from the data and keeps bit 0. It clears bit 1 or bit 2 where the data bit is 1 and keeps it where the data bit is 0. Bits 3, 4 and 7 read as zero.
- R6: Status bit 2 is set on an edge where the channel's `chanIrq` is high and its pending bit is low. Status bit 1 is set on an edge where `dmaFault` for that channel is high. A set in the same cycle as a clearing write wins.
- R7: The command byte stores bit 0 (start) and bit 3 (direction) and reads zero elsewhere. A command write copies its bit 0 into status bit 0 (active).
- R8: Each channel has its own read/write timing byte. It resets to `TIM0_INIT` for channel 0 and `TIM1_INIT` for channel 1.
- R9: The table pointer accepts writes sized by `wrSize`: 0 = byte at lane addr[1:0], 1 = halfword at lanes {addr[1],0}+0..1, 2 or 3 = word. Data comes from the low lanes of `wrData`. Pointer bits 1:0 always read as zero. A read at bank byte 4+k returns the pointer shifted right by 8k bits.
- R10: A synchronous reset clears command, status, mode and pointer registers and drives `irqOut` low on the next cycle.
- R11: `rdData` is combinational, valid in the cycle `rdEn` is high, and zero while `rdEn` is low. Byte registers appear in `rdData[7:0]` with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 4 | Byte offset within the 16-byte window |
| wrSize | input | 2 | Write size for the pointer: 0 byte, 1 halfword, 2/3 word |
| wrData | input | 32 | Write data, low-lane aligned |
| rdData | output | 32 | Read data |
| chanIrq | input | 2 | Level interrupt input per channel |
| dmaFault | input | 2 | One-cycle fault pulse per channel |
| irqOut | output | 1 | Combined interrupt line |

## Verification
The bench targets status cycles where a clearing write meets a new interrupt edge or fault. A design that lets the clear win would lose an event that software never saw.

It writes the mode byte with all ones and through the channel-1 alias. A design that decodes per bank, or lets pending bits be written, would then show a stale block bit or a phantom interrupt.

Halfword writes at odd pointer offsets and word writes with low bits set probe lane steering and alignment. A wrong lane base would corrupt a neighbouring pointer byte.

Random traffic with interrupts toggling under mixed block settings checks that `irqOut` tracks both channels. A design missing the block term, or the second channel, would disagree with the bench's model.

// File: rtl/idebm_pkg.sv
package idebm_pkg;
  localparam int CH_N      = 2;
  localparam int LANES     = 4;
  localparam int PTR_W     = 8 * LANES;
  localparam logic [7:0] CMD_KEEP  = 8'h09;
  localparam int OFF_CMD   = 0;
  localparam int OFF_MODE  = 1;
  localparam int OFF_STAT  = 2;
  localparam int OFF_TIM   = 3;

  typedef struct packed {
    logic [CH_N-1:0]            cmdWr;
    logic [CH_N-1:0]            stsWr;
    logic [CH_N-1:0]            timWr;
    logic                       modeWr;
    logic [CH_N-1:0][LANES-1:0] ptrLane;
    logic [PTR_W-1:0]           ptrData;
    logic [7:0]                 wrByte;
    logic                       rdOn;
    logic                       rdCh;
    logic [2:0]                 rdReg;
  } strobe_t;
endpackage

// File: rtl/idebm_ctrl.sv
module idebm_ctrl
  import idebm_pkg::*;
(
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [3:0]       addr,
  input  logic [1:0]       wrSize,
  input  logic [PTR_W-1:0] wrData,
  output strobe_t          stb
);
  logic [1:0]       laneBase;
  logic [LANES-1:0] laneMask;
  logic [LANES-1:0] laneEn;
  logic             ch;
  logic [2:0]       regSel;

  assign ch     = addr[3];
  assign regSel = addr[2:0];

  always_comb begin
    case (wrSize)
      2'd0:    begin laneBase = addr[1:0];        laneMask = 4'b0001; end
      2'd1:    begin laneBase = {addr[1], 1'b0};  laneMask = 4'b0011; end
      default: begin laneBase = 2'd0;             laneMask = 4'b1111; end
    endcase
    laneEn = laneMask << laneBase;
  end

  always_comb begin
    stb         = '0;
    stb.wrByte  = wrData[7:0];
    stb.ptrData = wrData << {laneBase, 3'b000};
    stb.rdOn    = rdEn;
    stb.rdCh    = ch;
    stb.rdReg   = regSel;
    if (wrEn) begin
      case (regSel)
        3'(OFF_CMD):  stb.cmdWr[ch]  = 1'b1;
        3'(OFF_MODE): stb.modeWr     = 1'b1;
        3'(OFF_STAT): stb.stsWr[ch]  = 1'b1;
        3'(OFF_TIM):  stb.timWr[ch]  = 1'b1;
        default:      stb.ptrLane[ch] = laneEn;
      endcase
    end
  end
endmodule

// File: rtl/idebm_dpath.sv
module idebm_dpath
  import idebm_pkg::*;
#(
  parameter logic [7:0] TIM0_INIT = 8'h00,
  parameter logic [7:0] TIM1_INIT = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [CH_N-1:0]  chanIrq,
  input  logic [CH_N-1:0]  dmaFault,
  output logic [PTR_W-1:0] rdData,
  output logic             irqOut,
  output logic [7:0]       modeQ,
  output logic [CH_N-1:0]  actQ
);
  logic [7:0]       cmdR  [CH_N];
  logic [7:0]       statR [CH_N];
  logic [7:0]       timR  [CH_N];
  logic [PTR_W-1:0] ptrR  [CH_N];

  // shared mode byte: pending in [3:2], block in [5:4]
  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= '0;
    end else begin
      modeQ[3:2] <= chanIrq;
      if (stb.modeWr) modeQ[5:4] <= stb.wrByte[5:4];
    end
  end

  assign irqOut = |(modeQ[3:2] & ~modeQ[5:4]);

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    localparam logic [7:0] TINIT = (c == 0) ? TIM0_INIT : TIM1_INIT;
    logic [7:0]       statNext;
    logic [PTR_W-1:0] ptrNext;

    always_comb begin
      statNext = statR[c];
      if (stb.stsWr[c]) begin
        statNext[6:5] = stb.wrByte[6:5];
        statNext[2:1] = statR[c][2:1] & ~stb.wrByte[2:1];
      end
      if (stb.cmdWr[c]) statNext[0] = stb.wrByte[0];
      if (chanIrq[c] && !modeQ[2+c]) statNext[2] = 1'b1;
      if (dmaFault[c]) statNext[1] = 1'b1;
    end

    always_comb begin
      ptrNext = ptrR[c];
      for (int l = 0; l < LANES; l++) begin
        if (stb.ptrLane[c][l]) ptrNext[8*l +: 8] = stb.ptrData[8*l +: 8];
      end
      ptrNext[1:0] = 2'b00;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cmdR[c]  <= '0;
        statR[c] <= '0;
        timR[c]  <= TINIT;
        ptrR[c]  <= '0;
      end else begin
        if (stb.cmdWr[c]) cmdR[c] <= stb.wrByte & CMD_KEEP;
        if (stb.timWr[c]) timR[c] <= stb.wrByte;
        statR[c] <= statNext;
        ptrR[c]  <= ptrNext;
      end
    end

    assign actQ[c] = statR[c][0];
  end

  always_comb begin
    rdData = '0;
    if (stb.rdOn) begin
      case (stb.rdReg)
        3'(OFF_CMD):  rdData = {24'b0, cmdR[stb.rdCh]};
        3'(OFF_MODE): rdData = {24'b0, modeQ};
        3'(OFF_STAT): rdData = {24'b0, statR[stb.rdCh]};
        3'(OFF_TIM):  rdData = {24'b0, timR[stb.rdCh]};
        default:      rdData = ptrR[stb.rdCh] >> {stb.rdReg[1:0], 3'b000};
      endcase
    end
  end
endmodule

// File: rtl/idebm_regs.sv
module idebm_regs
  import idebm_pkg::*;
#(
  parameter logic [7:0] TIM0_INIT = 8'h00,
  parameter logic [7:0] TIM1_INIT = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [3:0]  addr,
  input  logic [1:0]  wrSize,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [1:0]  chanIrq,
  input  logic [1:0]  dmaFault,
  output logic        irqOut
);
  strobe_t    stb;
  logic [7:0] modeQ;
  logic [1:0] actQ;

  idebm_ctrl u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrSize (wrSize),
    .wrData (wrData),
    .stb    (stb)
  );

  idebm_dpath #(
    .TIM0_INIT (TIM0_INIT),
    .TIM1_INIT (TIM1_INIT)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .chanIrq  (chanIrq),
    .dmaFault (dmaFault),
    .rdData   (rdData),
    .irqOut   (irqOut),
    .modeQ    (modeQ),
    .actQ     (actQ)
  );
endmodule

// File: rtl/idebm_regs_chk.sv
module idebm_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        wrEn,
  input logic        rdEn,
  input logic [3:0]  addr,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic [1:0]  chanIrq,
  input logic        irqOut,
  input logic [7:0]  modeQ,
  input logic [1:0]  actQ
);
  // R3
  pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> modeQ[3:2] == $past(chanIrq));

  // R2
  blk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && addr[2:0] == 3'd1) |=> $stable(modeQ[5:4]));

  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (modeQ[3:2] == 2'b00 || modeQ[5:4] == 2'b11) |-> !irqOut);

  // R7
  act_start_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr[2:0] == 3'd0) |=> actQ[$past(addr[3])] == $past(wrData[0]));

  // R9
  ptr_align_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr[2:0] == 3'd4) |-> rdData[1:0] == 2'b00);

  // R10
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> !irqOut);

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |-> rdData == 32'd0);
endmodule

bind idebm_regs idebm_regs_chk u_chk (.*);

// File: tb/idebm_regs_tb.sv
`timescale 1ns/100ps
module idebm_regs_tb;
  localparam logic [7:0] T0 = 8'h5A;
  localparam logic [7:0] T1 = 8'hC3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  wrSize = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  chanIrq = '0, dmaFault = '0;
  logic        irqOut;

  int nChk = 0, nFail = 0;
  bit done = 0;

  logic [7:0]  mCmd [2];
  logic [7:0]  mStat[2];
  logic [7:0]  mTim [2];
  logic [31:0] mPtr [2];
  logic [7:0]  mMode;

  idebm_regs #(.TIM0_INIT(T0), .TIM1_INIT(T1)) u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrSize(wrSize), .wrData(wrData), .rdData(rdData),
    .chanIrq(chanIrq), .dmaFault(dmaFault), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRd(input logic [3:0] off);
    int c = int'(off[3]);
    case (off[2:0])
      3'd0: return {24'b0, mCmd[c]};
      3'd1: return {24'b0, mMode};
      3'd2: return {24'b0, mStat[c]};
      3'd3: return {24'b0, mTim[c]};
      default: return mPtr[c] >> (8 * int'(off[1:0]));
    endcase
  endfunction

  function automatic logic expIrq();
    return (mMode[2] & ~mMode[4]) | (mMode[3] & ~mMode[5]);
  endfunction

  function automatic string tagOf(input logic [2:0] r);
    case (r)
      3'd0: return "R7 cmd";
      3'd1: return "R2 mode";
      3'd2: return "R5 R6 status";
      3'd3: return "R8 timing";
      default: return "R9 pointer";
    endcase
  endfunction

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mCmd[c] = '0; mStat[c] = '0; mPtr[c] = '0;
    end
    mTim[0] = T0; mTim[1] = T1; mMode = '0;
  endtask

  task automatic doReset();
    rst = 1'b1; wrEn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  // drive one cycle of stimulus, update the model at the edge
  task automatic step(input logic we, input logic [3:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic [1:0] irq, input logic [1:0] flt);
    logic [7:0]  nMode;
    logic [7:0]  s;
    logic [1:0]  base;
    logic [3:0]  mask;
    logic [31:0] sh;
    wrEn = we; addr = a; wrSize = sz; wrData = d; chanIrq = irq; dmaFault = flt; rdEn = 1'b0;
    @(posedge clk);
    nMode = mMode;
    nMode[3:2] = irq;
    if (we && a[2:0] == 3'd1) nMode[5:4] = d[5:4];
    case (sz)
      2'd0: begin base = a[1:0]; mask = 4'b0001; end
      2'd1: begin base = {a[1], 1'b0}; mask = 4'b0011; end
      default: begin base = 2'd0; mask = 4'b1111; end
    endcase
    mask = mask << base;
    sh = d << (8 * int'(base));
    for (int c = 0; c < 2; c++) begin
      s = mStat[c];
      if (we && int'(a[3]) == c) begin
        case (a[2:0])
          3'd0: begin mCmd[c] = d[7:0] & 8'h09; s[0] = d[0]; end
          3'd1: ;
          3'd2: begin s[6:5] = d[6:5]; s[2:1] = s[2:1] & ~d[2:1]; end
          3'd3: mTim[c] = d[7:0];
          default: begin
            for (int l = 0; l < 4; l++) if (mask[l]) mPtr[c][8*l +: 8] = sh[8*l +: 8];
            mPtr[c][1:0] = 2'b00;
          end
        endcase
      end
      if (irq[c] && !mMode[2+c]) s[2] = 1'b1;
      if (flt[c]) s[1] = 1'b1;
      mStat[c] = s;
    end
    mMode = nMode;
    @(negedge clk);
    wrEn = 1'b0; dmaFault = 2'b00;
  endtask

  // read every offset and the interrupt line inside the low clock phase
  task automatic checkAll(input string ctx);
    check(irqOut === expIrq(), {ctx, " R4 irqOut"}, 32'(irqOut), 32'(expIrq()));
    for (int o = 0; o < 16; o++) begin
      rdEn = 1'b1; addr = 4'(o);
      #0.5;
      check(rdData === expRd(4'(o)), {ctx, " R1 R11 ", tagOf(3'(o))}, rdData, expRd(4'(o)));
    end
    rdEn = 1'b0;
    #0.5;
    check(rdData === 32'd0, {ctx, " R11 idle read"}, rdData, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    checkAll("R10 reset");

    // R1: bank split and mode alias through channel 1
    step(1, 4'd3,  0, 32'h11, 2'b00, 2'b00);
    step(1, 4'd11, 0, 32'h22, 2'b00, 2'b00);
    step(1, 4'd9,  0, 32'h10, 2'b00, 2'b00);
    checkAll("R1 alias");
    // R2: all-ones mode write
    step(1, 4'd1, 0, 32'hFF, 2'b00, 2'b00);
    checkAll("R2 ones");
    // R3 R4: blocked then unblocked interrupts
    step(0, 4'd0, 0, 32'h0, 2'b01, 2'b00);
    checkAll("R4 blocked");
    step(1, 4'd1, 0, 32'h20, 2'b11, 2'b00);
    checkAll("R4 ch0 open");
    step(1, 4'd9, 0, 32'h10, 2'b10, 2'b00);
    checkAll("R3 ch1 open");
    // R6: edge set racing a clear, fault racing a clear
    step(0, 4'd0, 0, 32'h0, 2'b00, 2'b00);
    step(1, 4'd2, 0, 32'h04, 2'b01, 2'b00);
    checkAll("R6 set wins irq");
    step(1, 4'd2, 0, 32'h06, 2'b01, 2'b01);
    checkAll("R6 set wins fault");
    step(1, 4'd2, 0, 32'hFF, 2'b01, 2'b00);
    checkAll("R5 clear");
    // R7: command mask and active bit
    step(1, 4'd8, 0, 32'hFF, 2'b00, 2'b00);
    step(1, 4'd10, 0, 32'h00, 2'b00, 2'b00);
    checkAll("R7 start");
    step(1, 4'd8, 0, 32'h08, 2'b00, 2'b00);
    checkAll("R7 stop");
    // R9: pointer lanes
    step(1, 4'd4, 2, 32'h12345677, 2'b00, 2'b00);
    step(1, 4'd6, 0, 32'hFFFFFFAB, 2'b00, 2'b00);
    step(1, 4'd13, 1, 32'h0000BEEF, 2'b00, 2'b00);
    step(1, 4'd12, 0, 32'h000000FF, 2'b00, 2'b00);
    checkAll("R9 lanes");

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, 4'($urandom), 2'($urandom), $urandom,
           ($urandom % 4 == 0) ? 2'($urandom) : chanIrq, 2'(($urandom % 8 == 0) ? $urandom : 0));
      checkAll("random");
      if (i == 300) begin
        doReset();
        checkAll("R10 mid reset");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule